// File: doc/BRIEF.md
# Multi-bank uncached request issuer

This block holds the memory accesses of one instruction that skip the first-level data cache, and sends them into an interconnect injection port. Each access descriptor carries an address, a byte count, an access kind and the issuing warp. Descriptors are written into a small last-in-first-out store. When the pipeline asserts `issue_en`, the block offers up to one access per cache bank in that cycle. It starts from the most recently written descriptor and works toward older ones.

For every offered access the block computes the packet length: the payload bytes plus a header. The header is the write header for stores and the read header for everything else. The block presents this length, together with a write flag, to the interconnect on a per-lane probe. The interconnect answers with a per-lane full bit. Accepted accesses leave on consecutive request lanes and are removed from the store in the same cycle. The first lane that finds the interconnect full ends issue for that cycle and raises a registered reservation-fail stall. For every store that is sent, the block also reports a per-warp count of store requests.

Top module: `bypass_req_issuer`

## Requirements
- R1: After reset, `depth_used` is 0, `stall_rsv` is 0, and no request or probe lane is valid.
- R2: A descriptor is written, and `depth_used` rises by one on the next edge, only when `push_valid` is high, `issue_en` is low and `depth_used` is below DEPTH. `push_ready` is high exactly in that condition. Any other push has no effect.
- R3: Request lane k carries the k-th most recently written descriptor still held: its address, its kind and its warp. Valid request lanes always start at lane 0 and are contiguous. At most NB requests are sent per cycle.
- R4: The probe length on an attempted lane is the descriptor byte count plus WR_HDR (16) when the kind is store (code 1). It is the byte count plus RD_HDR (8) for load (code 0), atomic (code 2) and the unused code 3.
- R5: The probe write flag is 1 for store (code 1) and atomic (code 2), and 0 for the other kind codes.
- R6: On the lowest attempted lane whose `icnt_full` bit is set, no request is sent and no higher lane is attempted. `stall_rsv` is 1 after the next edge.
- R7: On an issue cycle, `depth_used` falls on the next edge by the number of valid request lanes.
- R8: `store_inc` field w (INC_W bits at offset w*INC_W) equals the number of valid request lanes this cycle that carry a store for warp w.
- R9: `stall_rsv` keeps its value through cycles with `issue_en` low. On an issue cycle where no attempted lane is full, it becomes 0 after the edge.
- R10: Lane k is attempted (`probe_valid[k]`) only when `issue_en` is high, more than k descriptors are held, and every lower lane was accepted. With `issue_en` low, no lane is attempted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Write a descriptor |
| push_ready | output | 1 | Write is accepted this cycle |
| push_addr | input | ADDR_W | Descriptor address |
| push_bytes | input | SIZE_W | Descriptor payload byte count |
| push_kind | input | 2 | 0 load, 1 store, 2 atomic, 3 unused (treated as read) |
| push_warp | input | WARP_W | Issuing warp |
| issue_en | input | 1 | Attempt issue this cycle |
| depth_used | output | CW | Descriptors held |
| probe_valid | output | NB | Lane is being offered to the interconnect |
| probe_bytes | output | NB*PKT_W | Per-lane packet length |
| probe_wr | output | NB | Per-lane write flag (store or atomic) |
| icnt_full | input | NB | Per-lane interconnect full answer |
| req_valid | output | NB | Request pushed on lane |
| req_addr | output | NB*ADDR_W | Request address per lane |
| req_bytes | output | NB*PKT_W | Request packet length per lane |
| req_kind | output | NB*2 | Request kind per lane |
| req_warp | output | NB*WARP_W | Request warp per lane |
| stall_rsv | output | 1 | Registered reservation-fail stall |
| store_inc | output | NWARP*INC_W | Per-warp store request increment |

## Verification
A wrong stack pointer or a corrupted entry shows up in the same cycle: the wrong address, kind or warp appears on the request lanes, and `depth_used` is wrong one edge later. A broken full chain shows up at once as a request on a lane above a full lane, or as a gap in the valid lanes. A stall register that does not update is seen on the cycle after the issue attempt, and a stall that does not hold is seen on the first idle cycle after it. The per-warp store count is compared every cycle against the accepted store lanes.

// File: rtl/bri_pkg.sv
package bri_pkg;

    typedef enum logic [1:0] {
        KIND_LOAD   = 2'd0,
        KIND_STORE  = 2'd1,
        KIND_ATOMIC = 2'd2,
        KIND_RSVD   = 2'd3
    } acc_kind_e;

    // write-ness as the interconnect sees it
    function automatic logic kind_is_write(input logic [1:0] k);
        return (k == KIND_STORE) || (k == KIND_ATOMIC);
    endfunction

    // only plain stores take the write header
    function automatic logic kind_uses_wr_hdr(input logic [1:0] k);
        return k == KIND_STORE;
    endfunction

endpackage

// File: rtl/bri_stack.sv
module bri_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    parameter int NB    = 4,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int PW   = $clog2(NB + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_en,
    input  logic [W-1:0]    push_data,
    input  logic [PW-1:0]   pop_n,
    output logic [CW-1:0]   count,
    output logic [NB*W-1:0] top_data
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [CW-1:0]           cnt;
    } stk_t;

    stk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pop_n != '0) begin
            st_d.cnt = st_q.cnt - CW'(pop_n);
        end else if (push_en && (st_q.cnt < CW'(DEPTH))) begin
            st_d.mem[AW'(st_q.cnt)] = push_data;
            st_d.cnt                = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    // lane k sees the entry k places below the top
    for (genvar k = 0; k < NB; k++) begin : g_top
        always_comb begin
            if (st_q.cnt > CW'(k))
                top_data[k*W +: W] = st_q.mem[AW'(st_q.cnt - CW'(k + 1))];
            else
                top_data[k*W +: W] = '0;
        end
    end

endmodule

// File: rtl/bri_lane_ctl.sv
module bri_lane_ctl
    import bri_pkg::*;
#(
    parameter int NB     = 4,
    parameter int DEPTH  = 8,
    parameter int SIZE_W = 8,
    parameter int PKT_W  = 9,
    parameter int WR_HDR = 16,
    parameter int RD_HDR = 8,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int PW    = $clog2(NB + 1)
) (
    input  logic                issue_en,
    input  logic [CW-1:0]       count,
    input  logic [NB*2-1:0]     lane_kind,
    input  logic [NB*SIZE_W-1:0] lane_size,
    input  logic [NB-1:0]       icnt_full,
    output logic [NB-1:0]       probe_valid,
    output logic [NB*PKT_W-1:0] probe_bytes,
    output logic [NB-1:0]       probe_wr,
    output logic [NB-1:0]       go,
    output logic                fail,
    output logic [PW-1:0]       pop_n
);

    // per-lane packet length and write flag
    for (genvar k = 0; k < NB; k++) begin : g_len
        logic [1:0] kd;
        assign kd = lane_kind[k*2 +: 2];
        always_comb begin
            probe_bytes[k*PKT_W +: PKT_W] = PKT_W'(lane_size[k*SIZE_W +: SIZE_W])
                + (kind_uses_wr_hdr(kd) ? PKT_W'(WR_HDR) : PKT_W'(RD_HDR));
            probe_wr[k] = kind_is_write(kd);
        end
    end

    // ordered chain: stop at the first full lane or at the end of the queue
    always_comb begin
        logic alive;
        alive       = issue_en;
        probe_valid = '0;
        go          = '0;
        fail        = 1'b0;
        pop_n       = '0;
        for (int k = 0; k < NB; k++) begin
            if (alive && (count > CW'(k))) begin
                probe_valid[k] = 1'b1;
                if (icnt_full[k]) begin
                    fail  = 1'b1;
                    alive = 1'b0;
                end else begin
                    go[k] = 1'b1;
                    pop_n = pop_n + PW'(1);
                end
            end else begin
                alive = 1'b0;
            end
        end
    end

endmodule

// File: rtl/bri_store_tally.sv
module bri_store_tally
    import bri_pkg::*;
#(
    parameter int NB     = 4,
    parameter int NWARP  = 8,
    parameter int WARP_W = 3,
    localparam int INC_W = $clog2(NB + 1)
) (
    input  logic [NB-1:0]          go,
    input  logic [NB*2-1:0]        lane_kind,
    input  logic [NB*WARP_W-1:0]   lane_warp,
    output logic [NWARP*INC_W-1:0] store_inc
);

    for (genvar w = 0; w < NWARP; w++) begin : g_warp
        always_comb begin
            logic [INC_W-1:0] n;
            n = '0;
            for (int k = 0; k < NB; k++) begin
                if (go[k] && (lane_kind[k*2 +: 2] == KIND_STORE)
                          && (lane_warp[k*WARP_W +: WARP_W] == WARP_W'(w)))
                    n = n + INC_W'(1);
            end
            store_inc[w*INC_W +: INC_W] = n;
        end
    end

endmodule

// File: rtl/bypass_req_issuer.sv
module bypass_req_issuer
    import bri_pkg::*;
#(
    parameter int NB     = 4,
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 8,
    parameter int WARP_W = 3,
    parameter int NWARP  = 8,
    parameter int PKT_W  = 9,
    parameter int WR_HDR = 16,
    parameter int RD_HDR = 8,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int PW    = $clog2(NB + 1),
    localparam int INC_W = $clog2(NB + 1),
    localparam int EW    = ADDR_W + SIZE_W + 2 + WARP_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push_valid,
    output logic                    push_ready,
    input  logic [ADDR_W-1:0]       push_addr,
    input  logic [SIZE_W-1:0]       push_bytes,
    input  logic [1:0]              push_kind,
    input  logic [WARP_W-1:0]       push_warp,
    input  logic                    issue_en,
    output logic [CW-1:0]           depth_used,
    output logic [NB-1:0]           probe_valid,
    output logic [NB*PKT_W-1:0]     probe_bytes,
    output logic [NB-1:0]           probe_wr,
    input  logic [NB-1:0]           icnt_full,
    output logic [NB-1:0]           req_valid,
    output logic [NB*ADDR_W-1:0]    req_addr,
    output logic [NB*PKT_W-1:0]     req_bytes,
    output logic [NB*2-1:0]         req_kind,
    output logic [NB*WARP_W-1:0]    req_warp,
    output logic                    stall_rsv,
    output logic [NWARP*INC_W-1:0]  store_inc
);

    typedef struct packed {
        logic stall;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [EW-1:0]        entry_in;
    logic [NB*EW-1:0]     top_data;
    logic [NB*2-1:0]      lane_kind;
    logic [NB*SIZE_W-1:0] lane_size;
    logic [NB*WARP_W-1:0] lane_warp;
    logic [NB*ADDR_W-1:0] lane_addr;
    logic [NB-1:0]        go;
    logic                 fail;
    logic [PW-1:0]        pop_n;

    // writes and issue never share a cycle
    assign push_ready = !issue_en && (depth_used < CW'(DEPTH));
    assign entry_in   = {push_addr, push_bytes, push_kind, push_warp};

    bri_stack #(
        .DEPTH (DEPTH),
        .W     (EW),
        .NB    (NB)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (push_valid && push_ready),
        .push_data (entry_in),
        .pop_n     (pop_n),
        .count     (depth_used),
        .top_data  (top_data)
    );

    // split each lane's entry into its fields
    for (genvar k = 0; k < NB; k++) begin : g_split
        assign lane_warp[k*WARP_W +: WARP_W] = top_data[k*EW +: WARP_W];
        assign lane_kind[k*2 +: 2]           = top_data[k*EW + WARP_W +: 2];
        assign lane_size[k*SIZE_W +: SIZE_W] = top_data[k*EW + WARP_W + 2 +: SIZE_W];
        assign lane_addr[k*ADDR_W +: ADDR_W] = top_data[k*EW + WARP_W + 2 + SIZE_W +: ADDR_W];
    end

    bri_lane_ctl #(
        .NB     (NB),
        .DEPTH  (DEPTH),
        .SIZE_W (SIZE_W),
        .PKT_W  (PKT_W),
        .WR_HDR (WR_HDR),
        .RD_HDR (RD_HDR)
    ) u_lanes (
        .issue_en    (issue_en),
        .count       (depth_used),
        .lane_kind   (lane_kind),
        .lane_size   (lane_size),
        .icnt_full   (icnt_full),
        .probe_valid (probe_valid),
        .probe_bytes (probe_bytes),
        .probe_wr    (probe_wr),
        .go          (go),
        .fail        (fail),
        .pop_n       (pop_n)
    );

    bri_store_tally #(
        .NB     (NB),
        .NWARP  (NWARP),
        .WARP_W (WARP_W)
    ) u_tally (
        .go        (go),
        .lane_kind (lane_kind),
        .lane_warp (lane_warp),
        .store_inc (store_inc)
    );

    // request lanes: gated copies of the accepted entries
    for (genvar k = 0; k < NB; k++) begin : g_req
        assign req_valid[k]                 = go[k];
        assign req_addr[k*ADDR_W +: ADDR_W] = go[k] ? lane_addr[k*ADDR_W +: ADDR_W] : '0;
        assign req_bytes[k*PKT_W +: PKT_W]  = go[k] ? probe_bytes[k*PKT_W +: PKT_W] : '0;
        assign req_kind[k*2 +: 2]           = go[k] ? lane_kind[k*2 +: 2] : '0;
        assign req_warp[k*WARP_W +: WARP_W] = go[k] ? lane_warp[k*WARP_W +: WARP_W] : '0;
    end

    // stall is re-evaluated on every issue attempt, held otherwise
    always_comb begin
        st_d = st_q;
        if (issue_en) st_d.stall = fail;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stall_rsv = st_q.stall;

endmodule

// File: rtl/bri_checker.sv
module bri_checker #(
    parameter int NB    = 4,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          issue_en,
    input logic          push_valid,
    input logic          push_ready,
    input logic [CW-1:0] depth_used,
    input logic [NB-1:0] probe_valid,
    input logic [NB-1:0] icnt_full,
    input logic [NB-1:0] req_valid,
    input logic          stall_rsv
);

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        depth_used <= CW'(DEPTH));

    p_push_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_en |-> !push_ready);

    p_push_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_ready) |=> depth_used == $past(depth_used) + CW'(1));

    p_lanes_contig_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid & (req_valid + NB'(1))) == '0);

    p_full_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid & ~(probe_valid & ~icnt_full)) == '0);

    p_stall_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_en && ((probe_valid & icnt_full) != '0)) |=> stall_rsv);

    p_pop_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        issue_en |=> depth_used == $past(depth_used) - CW'($countones($past(req_valid))));

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_en |=> $stable(stall_rsv));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_en |-> probe_valid == '0);

endmodule

bind bypass_req_issuer bri_checker #(
    .NB    (NB),
    .DEPTH (DEPTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_en    (issue_en),
    .push_valid  (push_valid),
    .push_ready  (push_ready),
    .depth_used  (depth_used),
    .probe_valid (probe_valid),
    .icnt_full   (icnt_full),
    .req_valid   (req_valid),
    .stall_rsv   (stall_rsv)
);

// File: tb/sim_bypass_req_issuer.sv
module sim_bypass_req_issuer;

    localparam int NB = 4, DEPTH = 8, ADDR_W = 32, SIZE_W = 8, WARP_W = 3;
    localparam int NWARP = 8, PKT_W = 9, WR_HDR = 16, RD_HDR = 8;
    localparam int CW = $clog2(DEPTH + 1), INC_W = $clog2(NB + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic push_valid = 1'b0, issue_en = 1'b0;
    logic [ADDR_W-1:0] push_addr = '0;
    logic [SIZE_W-1:0] push_bytes = '0;
    logic [1:0] push_kind = '0;
    logic [WARP_W-1:0] push_warp = '0;
    logic [NB-1:0] icnt_full = '0;
    logic push_ready, stall_rsv;
    logic [CW-1:0] depth_used;
    logic [NB-1:0] probe_valid, probe_wr, req_valid;
    logic [NB*PKT_W-1:0] probe_bytes, req_bytes;
    logic [NB*ADDR_W-1:0] req_addr;
    logic [NB*2-1:0] req_kind;
    logic [NB*WARP_W-1:0] req_warp;
    logic [NWARP*INC_W-1:0] store_inc;

    always #4 clk = ~clk;   // 125 MHz

    bypass_req_issuer u0 (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(push_ready),
        .push_addr(push_addr), .push_bytes(push_bytes), .push_kind(push_kind),
        .push_warp(push_warp), .issue_en(issue_en), .depth_used(depth_used),
        .probe_valid(probe_valid), .probe_bytes(probe_bytes), .probe_wr(probe_wr),
        .icnt_full(icnt_full), .req_valid(req_valid), .req_addr(req_addr),
        .req_bytes(req_bytes), .req_kind(req_kind), .req_warp(req_warp),
        .stall_rsv(stall_rsv), .store_inc(store_inc)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // reference model
    int        m_cnt = 0;
    bit        m_stall = 1'b0;
    logic [ADDR_W-1:0] m_addr [DEPTH];
    logic [SIZE_W-1:0] m_size [DEPTH];
    logic [1:0]        m_kind [DEPTH];
    logic [WARP_W-1:0] m_warp [DEPTH];

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_len(input logic [1:0] k, input logic [SIZE_W-1:0] s);
        return int'(s) + ((k == 2'd1) ? WR_HDR : RD_HDR);
    endfunction

    function automatic bit exp_wr(input logic [1:0] k);
        return (k == 2'd1) || (k == 2'd2);
    endfunction

    task automatic step(input bit pv, input logic [ADDR_W-1:0] pa, input logic [SIZE_W-1:0] pb,
                        input logic [1:0] pk, input logic [WARP_W-1:0] pw,
                        input bit ie, input logic [NB-1:0] fl);
        bit exp_rdy, alive, fail_c;
        int n_go;
        int inc [NWARP];
        @(negedge clk);
        push_valid = pv; push_addr = pa; push_bytes = pb; push_kind = pk;
        push_warp = pw; issue_en = ie; icnt_full = fl;
        #2;
        exp_rdy = !ie && (m_cnt < DEPTH);
        check("R2 push_ready", 64'(push_ready), 64'(exp_rdy));
        for (int w = 0; w < NWARP; w++) inc[w] = 0;
        alive = ie; fail_c = 1'b0; n_go = 0;
        for (int k = 0; k < NB; k++) begin
            bit att;
            att = alive && (m_cnt > k);
            check("R10 probe_valid", 64'(probe_valid[k]), 64'(att));
            if (att) begin
                int idx;
                idx = m_cnt - 1 - k;
                check("R4 probe_bytes", 64'(probe_bytes[k*PKT_W +: PKT_W]),
                      64'(exp_len(m_kind[idx], m_size[idx])));
                check("R5 probe_wr", 64'(probe_wr[k]), 64'(exp_wr(m_kind[idx])));
                if (fl[k]) begin
                    fail_c = 1'b1; alive = 1'b0;
                    check("R6 req_valid blocked", 64'(req_valid[k]), 64'(0));
                end else begin
                    check("R3 req_valid", 64'(req_valid[k]), 64'(1));
                    check("R3 req_addr", 64'(req_addr[k*ADDR_W +: ADDR_W]), 64'(m_addr[idx]));
                    check("R3 req_kind", 64'(req_kind[k*2 +: 2]), 64'(m_kind[idx]));
                    check("R3 req_warp", 64'(req_warp[k*WARP_W +: WARP_W]), 64'(m_warp[idx]));
                    if (m_kind[idx] == 2'd1) inc[m_warp[idx]]++;
                    n_go++;
                end
            end else begin
                alive = 1'b0;
                check("R10 req_valid idle", 64'(req_valid[k]), 64'(0));
            end
        end
        for (int w = 0; w < NWARP; w++)
            check("R8 store_inc", 64'(store_inc[w*INC_W +: INC_W]), 64'(inc[w]));
        @(posedge clk);
        #1;
        if (exp_rdy && pv) begin
            m_addr[m_cnt] = pa; m_size[m_cnt] = pb; m_kind[m_cnt] = pk; m_warp[m_cnt] = pw;
            m_cnt++;
        end
        m_cnt -= n_go;
        if (ie) m_stall = fail_c;
        check("R7 depth_used", 64'(depth_used), 64'(m_cnt));
        check(ie ? "R6 stall_rsv" : "R9 stall_rsv", 64'(stall_rsv), 64'(m_stall));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R1 depth", 64'(depth_used), 64'(0));
        check("R1 stall", 64'(stall_rsv), 64'(0));
        check("R1 req_valid", 64'(req_valid), 64'(0));
        check("R1 probe_valid", 64'(probe_valid), 64'(0));
        @(negedge clk); rst_n = 1'b1;

        // fill with mixed kinds, then one extra push that must be ignored (R2)
        for (int i = 0; i < DEPTH; i++)
            step(1'b1, 32'h1000 + 32'(i * 64), 8'(4 * (i + 1)), 2'(i % 4), 3'(i), 1'b0, '0);
        step(1'b1, 32'hdead, 8'd9, 2'd1, 3'd7, 1'b0, '0);
        // push alongside issue is ignored (R2), four lanes leave (R3)
        step(1'b1, 32'hbeef, 8'd9, 2'd1, 3'd7, 1'b1, '0);
        // lane 2 full: two leave, stall raised (R6)
        step(1'b0, '0, '0, '0, '0, 1'b1, 4'b0100);
        // stall held while idle (R9)
        step(1'b0, '0, '0, '0, '0, 1'b0, '0);
        step(1'b0, '0, '0, '0, '0, 1'b0, 4'b1111);
        // last two leave, upper lanes not tried (R10), stall cleared (R9)
        step(1'b0, '0, '0, '0, '0, 1'b1, '0);
        // issue on empty queue
        step(1'b0, '0, '0, '0, '0, 1'b1, '0);
        // four stores from one warp counted together (R8)
        for (int i = 0; i < 5; i++)
            step(1'b1, 32'h2000 + 32'(i), 8'd32, 2'd1, 3'd3, 1'b0, '0);
        step(1'b0, '0, '0, '0, '0, 1'b1, '0);
        // lane 0 full: nothing leaves (R6)
        step(1'b0, '0, '0, '0, '0, 1'b1, 4'b0001);
        step(1'b0, '0, '0, '0, '0, 1'b1, '0);

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [NB-1:0] fl;
            for (int k = 0; k < NB; k++) fl[k] = ($urandom % 4) == 0;
            step(($urandom % 10) < 7, $urandom, 8'($urandom), 2'($urandom),
                 3'($urandom), ($urandom % 10) < 4, fl);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule